// File: doc/BRIEF.md
# Dual-Clock FIFO Occupancy Flag Generator

This block produces the occupancy status of a dual-clock FIFO whose storage and data path live elsewhere. It tracks a write pointer in the write-clock domain and a read pointer in the read-clock domain. Each pointer crosses to the other domain as Gray code through a two-flop synchronizer, and each domain derives its own view of the word count. From these two views it builds an active-low almost-empty flag and an active-low half-full flag. Each domain also reports its word count.

Two choices are captured while master reset is high and then held. The first is the output style. In first-word-fall-through operation the output register adds one word of capacity, so every threshold moves up by one. The second is whether almost-empty is a read-clock registered flag or a flag that is set by read-clock events and cleared by write-clock events. The half-full flag always uses the split form: the write side asserts it and the read side releases it.

Top module: `dcf_flag_gen`

## Requirements
- R1: While `mrst` is high, both pointers clear. Once it is released, `wr_words` and `rd_words` read 0, `ae_n` is low and `hf_n` is high.
- R2: A write strobe is accepted only while the write-side count is below the capacity. The capacity is D = 2^ADDR_W words with `fwft_sel` latched 0, and D+1 words with it latched 1. A write strobe at capacity leaves `wr_words` unchanged.
- R3: A read strobe while the read-side count is 0 is ignored, and `rd_words` stays 0.
- R4: With `ae_timing_sel` latched 1 and `fwft_sel` latched 0, `ae_n` is a read-clock register. It is low when the read-side count is at most n and high otherwise, where n is the latched `ae_offset`. It follows a read within two read-clock edges.
- R5: With `fwft_sel` latched 1, the almost-empty threshold is n+1 words. The flag is low at n+1 or fewer words and high from n+2.
- R6: With `ae_timing_sel` latched 0, a read-clock event that brings the read-side count to the threshold or below drives `ae_n` low. A write-clock event that brings the write-side count above the threshold drives it high. Each takes effect within two edges of the clock that causes it.
- R7: `hf_n` goes low within two write-clock edges of the write-side count reaching D/2+1, or D/2+2 in first-word-fall-through operation. It returns high within two read-clock edges of the read-side count dropping below that level.
- R8: `fwft_sel`, `ae_timing_sel` and `ae_offset` are sampled only while `mrst` is high. Changing them later has no effect on capacity, thresholds or flag style.
- R9: Pointers cross domains in Gray code, changing at most one bit per clock. Once both sides have been idle for eight cycles of each clock, both counts equal the true occupancy and both flags match it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| wen | input | 1 | Write strobe, one word per cycle |
| rclk | input | 1 | Read-domain clock |
| ren | input | 1 | Read strobe, one word per cycle |
| mrst | input | 1 | Master reset, active high, sampled synchronously in each domain |
| fwft_sel | input | 1 | 1 selects first-word-fall-through thresholds, latched in reset |
| ae_timing_sel | input | 1 | 1 = registered almost-empty, 0 = split-domain almost-empty, latched in reset |
| ae_offset | input | ADDR_W | Almost-empty offset n, latched in reset |
| ae_n | output | 1 | Almost-empty flag, active low |
| hf_n | output | 1 | Half-full flag, active low |
| wr_words | output | ADDR_W+1 | Word count seen by the write domain |
| rd_words | output | ADDR_W+1 | Word count seen by the read domain |

## Verification
The bench builds the block with ADDR_W = 3, which gives an eight-word array. With that size, full, overfull, half-full in both output styles and every almost-empty offset are reached within a few strobes, so random bursts cross each flag boundary many times. Unrelated clock periods keep the pointer synchronizers sampling at shifting phases. Each flag edge is checked within the two-edge bound of the domain that owns it. A full comparison against the reference occupancy is made after each idle gap.

// File: rtl/dcf_flag_pkg.sv
package dcf_flag_pkg;

    typedef enum logic {
        AE_SPLIT = 1'b0,
        AE_REGD  = 1'b1
    } ae_timing_e;

    typedef struct packed {
        logic       fwft;
        ae_timing_e timing;
    } flag_mode_t;

    function automatic int unsigned capacity(input int unsigned depth, input logic fwft);
        return depth + (fwft ? 1 : 0);
    endfunction

    function automatic int unsigned hf_level(input int unsigned depth, input logic fwft);
        return depth / 2 + 1 + (fwft ? 1 : 0);
    endfunction

    function automatic int unsigned ae_level(input int unsigned offset, input logic fwft);
        return offset + (fwft ? 1 : 0);
    endfunction

endpackage

// File: rtl/dcf_sync_bus.sv
module dcf_sync_bus #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_xflag.sv
module dcf_xflag #(
    parameter bit RST_ON = 1'b0
) (
    input  logic clk_s,
    input  logic clk_c,
    input  logic rst,
    input  logic set_cond,
    input  logic clr_cond,
    output logic asserted
);
    logic tog_s, tog_c;
    logic s_seen, s_meta;
    logic c_seen, c_meta;

    always_ff @(posedge clk_s) begin
        if (rst) begin
            c_meta <= RST_ON;
            c_seen <= RST_ON;
            tog_s  <= 1'b0;
        end else begin
            c_meta <= tog_c;
            c_seen <= c_meta;
            if (set_cond && (tog_s == c_seen))
                tog_s <= ~tog_s;
        end
    end

    always_ff @(posedge clk_c) begin
        if (rst) begin
            s_meta <= 1'b0;
            s_seen <= 1'b0;
            tog_c  <= RST_ON;
        end else begin
            s_meta <= tog_s;
            s_seen <= s_meta;
            if (clr_cond && (tog_c != s_seen))
                tog_c <= ~tog_c;
        end
    end

    assign asserted = tog_s ^ tog_c;

    // R7 / R6: a set event cannot repeat before the clear side has answered
    p_set_hold_r7: assert property (@(posedge clk_s) disable iff (rst)
        !$stable(tog_s) |=> $stable(tog_s));

    // R6 / R7: same for the clearing side
    p_clr_hold_r6: assert property (@(posedge clk_c) disable iff (rst)
        !$stable(tog_c) |=> $stable(tog_c));
endmodule

// File: rtl/dcf_ptr_side.sv
module dcf_ptr_side
    import dcf_flag_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter bit WRITER = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              fwft,
    input  logic [ADDR_W+1:0] peer_gray,
    output logic [ADDR_W+1:0] own_gray,
    output logic [ADDR_W:0]   count
);
    localparam int PTR_W = ADDR_W + 2;
    localparam int CNT_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PTR_W-1:0] own_bin, next_bin, peer_sync, peer_bin;
    logic [CNT_W-1:0] cap;
    logic             take;

    dcf_sync_bus #(.W(PTR_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (peer_gray),
        .q   (peer_sync)
    );

    always_comb begin
        peer_bin[PTR_W-1] = peer_sync[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--)
            peer_bin[i] = peer_bin[i+1] ^ peer_sync[i];
    end

    assign cap      = CNT_W'(capacity(DEPTH, fwft));
    assign next_bin = own_bin + PTR_W'(1);

    generate
        if (WRITER) begin : g_wr
            assign count = CNT_W'(own_bin - peer_bin);
            assign take  = req && (count < cap);
        end else begin : g_rd
            assign count = CNT_W'(peer_bin - own_bin);
            assign take  = req && (count != '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            own_bin  <= '0;
            own_gray <= '0;
        end else if (take) begin
            own_bin  <= next_bin;
            own_gray <= next_bin ^ (next_bin >> 1);
        end
    end

    p_gray_step_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(own_gray ^ $past(own_gray)) <= 1);

    p_cnt_cap_r2: assert property (@(posedge clk) disable iff (rst)
        count <= cap);

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (own_bin != $past(own_bin)) |-> (own_bin == $past(own_bin) + PTR_W'(1)));
endmodule

// File: rtl/dcf_flag_gen.sv
module dcf_flag_gen
    import dcf_flag_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              wclk,
    input  logic              wen,
    input  logic              rclk,
    input  logic              ren,
    input  logic              mrst,
    input  logic              fwft_sel,
    input  logic              ae_timing_sel,
    input  logic [ADDR_W-1:0] ae_offset,
    output logic              ae_n,
    output logic              hf_n,
    output logic [ADDR_W:0]   wr_words,
    output logic [ADDR_W:0]   rd_words
);
    localparam int PTR_W = ADDR_W + 2;
    localparam int CNT_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic              fwft_w;
    logic [ADDR_W-1:0] off_w;
    flag_mode_t        mode_r;
    logic [ADDR_W-1:0] off_r;

    logic [PTR_W-1:0]  w_gray, r_gray;
    logic [CNT_W-1:0]  wcnt, rcnt;
    logic [CNT_W-1:0]  hf_th_w, hf_th_r, ae_th_w, ae_th_r;
    logic              hf_on, ae_split_on, ae_regd_on;

    // configuration captured only during master reset (R8)
    always_ff @(posedge wclk) begin
        if (mrst) begin
            fwft_w <= fwft_sel;
            off_w  <= ae_offset;
        end
    end

    always_ff @(posedge rclk) begin
        if (mrst) begin
            mode_r <= '{fwft: fwft_sel, timing: ae_timing_e'(ae_timing_sel)};
            off_r  <= ae_offset;
        end
    end

    assign hf_th_w = CNT_W'(hf_level(DEPTH, fwft_w));
    assign hf_th_r = CNT_W'(hf_level(DEPTH, mode_r.fwft));
    assign ae_th_w = CNT_W'(ae_level(int'(off_w), fwft_w));
    assign ae_th_r = CNT_W'(ae_level(int'(off_r), mode_r.fwft));

    dcf_ptr_side #(.ADDR_W(ADDR_W), .WRITER(1'b1)) u_wside (
        .clk       (wclk),
        .rst       (mrst),
        .req       (wen),
        .fwft      (fwft_w),
        .peer_gray (r_gray),
        .own_gray  (w_gray),
        .count     (wcnt)
    );

    dcf_ptr_side #(.ADDR_W(ADDR_W), .WRITER(1'b0)) u_rside (
        .clk       (rclk),
        .rst       (mrst),
        .req       (ren),
        .fwft      (mode_r.fwft),
        .peer_gray (w_gray),
        .own_gray  (r_gray),
        .count     (rcnt)
    );

    // half-full: set from write side, cleared from read side (R7)
    dcf_xflag #(.RST_ON(1'b0)) u_hf (
        .clk_s    (wclk),
        .clk_c    (rclk),
        .rst      (mrst),
        .set_cond (wcnt >= hf_th_w),
        .clr_cond (rcnt < hf_th_r),
        .asserted (hf_on)
    );

    // split almost-empty: set from read side, cleared from write side (R6)
    dcf_xflag #(.RST_ON(1'b1)) u_ae (
        .clk_s    (rclk),
        .clk_c    (wclk),
        .rst      (mrst),
        .set_cond (rcnt <= ae_th_r),
        .clr_cond (wcnt > ae_th_w),
        .asserted (ae_split_on)
    );

    // registered almost-empty in the read domain (R4, R5)
    always_ff @(posedge rclk) begin
        if (mrst) ae_regd_on <= 1'b1;
        else      ae_regd_on <= (rcnt <= ae_th_r);
    end

    assign ae_n     = ~((mode_r.timing == AE_REGD) ? ae_regd_on : ae_split_on);
    assign hf_n     = ~hf_on;
    assign wr_words = wcnt;
    assign rd_words = rcnt;

    p_mode_hold_r8: assert property (@(posedge rclk) disable iff (mrst)
        !$past(mrst) |-> ($stable(mode_r) && $stable(off_r)));

    p_wcfg_hold_r8: assert property (@(posedge wclk) disable iff (mrst)
        !$past(mrst) |-> ($stable(fwft_w) && $stable(off_w)));

    p_empty_flag_r4: assert property (@(posedge rclk) disable iff (mrst)
        (mode_r.timing == AE_REGD && $past(rcnt) == '0 && !$past(mrst)) |-> !ae_n);
endmodule

// File: tb/dcf_flag_gen_tb.sv
`timescale 1ns/1ps
module dcf_flag_gen_tb;
    localparam int AW = 3;
    localparam int D  = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0;
    logic wen = 1'b0, ren = 1'b0, mrst = 1'b1;
    logic fwft_sel = 1'b0, ae_timing_sel = 1'b1;
    logic [AW-1:0] ae_offset = '0;
    logic ae_n, hf_n;
    logic [AW:0] wr_words, rd_words;

    int nchk = 0, nerr = 0;
    int occ = 0;
    int m_fwft = 0, m_split = 0, m_off = 0;

    always #2.5 wclk = ~wclk;
    always #3.7 rclk = ~rclk;

    dcf_flag_gen #(.ADDR_W(AW)) u_dut (
        .wclk(wclk), .wen(wen), .rclk(rclk), .ren(ren), .mrst(mrst),
        .fwft_sel(fwft_sel), .ae_timing_sel(ae_timing_sel), .ae_offset(ae_offset),
        .ae_n(ae_n), .hf_n(hf_n), .wr_words(wr_words), .rd_words(rd_words)
    );

    function automatic int cap_f();    return D + m_fwft;         endfunction
    function automatic int hf_th_f();  return D / 2 + 1 + m_fwft; endfunction
    function automatic int ae_th_f();  return m_off + m_fwft;     endfunction
    function automatic string ae_req();
        return (m_split != 0) ? "R6" : ((m_fwft != 0) ? "R5" : "R4");
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d (occ=%0d)", req, act, exp, occ);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic do_reset(input int f, input int regd, input int off);
        @(negedge wclk);
        mrst = 1'b1; fwft_sel = f[0]; ae_timing_sel = regd[0]; ae_offset = AW'(off);
        repeat (12) @(negedge wclk);
        mrst = 1'b0;
        m_fwft = f; m_split = (regd == 0) ? 1 : 0; m_off = off; occ = 0;
        repeat (3) @(negedge rclk);
        repeat (2) @(negedge wclk);
        chk("R1 wr_words", int'(wr_words), 0);
        chk("R1 rd_words", int'(rd_words), 0);
        chk("R1 ae_n", int'(ae_n), 0);
        chk("R1 hf_n", int'(hf_n), 1);
    endtask

    task automatic wr_op();
        @(negedge wclk); wen = 1'b1;
        @(negedge wclk); wen = 1'b0;
        if (occ < cap_f()) occ++;
        repeat (2) @(negedge wclk);
        chk("R2 wr_words", int'(wr_words), occ);
        if (occ >= hf_th_f()) chk("R7 hf set", int'(hf_n), 0);
        if (m_split != 0 && occ > ae_th_f()) chk("R6 ae release", int'(ae_n), 1);
    endtask

    task automatic rd_op();
        @(negedge rclk); ren = 1'b1;
        @(negedge rclk); ren = 1'b0;
        if (occ > 0) occ--;
        repeat (2) @(negedge rclk);
        chk("R3 rd_words", int'(rd_words), occ);
        if (occ < hf_th_f()) chk("R7 hf release", int'(hf_n), 1);
        if (occ <= ae_th_f()) chk({ae_req(), " ae set"}, int'(ae_n), 0);
    endtask

    task automatic settle_check();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
        chk("R9 wr_words", int'(wr_words), occ);
        chk("R9 rd_words", int'(rd_words), occ);
        chk("R7 hf_n", int'(hf_n), (occ >= hf_th_f()) ? 0 : 1);
        chk({ae_req(), " ae_n"}, int'(ae_n), (occ <= ae_th_f()) ? 0 : 1);
    endtask

    task automatic random_rounds(input int n);
        for (int k = 0; k < n; k++) begin
            int len;
            len = int'($urandom_range(1, cap_f() + 2));
            if ($urandom_range(0, 1) == 1) begin
                for (int j = 0; j < len; j++) wr_op();
            end else begin
                for (int j = 0; j < len; j++) rd_op();
            end
            settle_check();
        end
    endtask

    initial begin
        #900000;
        nerr++;
        $display("FAIL R9 watchdog: got 0 expected 1 (run did not finish)");
        summary();
    end

    initial begin
        void'($urandom(32'd2718));

        // standard, registered almost-empty, n=2
        do_reset(0, 1, 2);
        for (int j = 0; j < D + 2; j++) wr_op();   // R2 overfill ignored
        settle_check();
        for (int j = 0; j < D + 2; j++) rd_op();   // R3 underflow ignored
        settle_check();
        random_rounds(30);

        // fall-through, registered, n=3
        do_reset(1, 1, 3);
        for (int j = 0; j < D + 3; j++) wr_op();   // R5 capacity D+1
        settle_check();
        random_rounds(30);

        // standard, split almost-empty, n=1
        do_reset(0, 0, 1);
        random_rounds(30);

        // fall-through, split almost-empty, n=0
        do_reset(1, 0, 0);
        random_rounds(20);

        // R8: inputs changed after reset have no effect
        do_reset(0, 1, 4);
        @(negedge wclk);
        fwft_sel = 1'b1; ae_timing_sel = 1'b0; ae_offset = '0;
        for (int j = 0; j < D + 1; j++) wr_op();
        settle_check();
        chk("R8 capacity kept", int'(wr_words), D);
        for (int j = 0; j < 4; j++) rd_op();
        settle_check();
        chk("R8 offset kept", int'(ae_n), 0);
        random_rounds(10);

        summary();
    end
endmodule